// File: doc/BRIEF.md
# Time-Shared Cascaded PID Engine

This block closes the position, velocity and current loops of several motor axes with one multiplier and one adder, used in turn. A start strobe begins one pass. The sequencer walks the axes in ascending order. Within each axis it runs the position loop, then the velocity loop, then the current loop. Each loop is taken apart into an error subtraction, a proportional product, an integral product, a derivative difference, a derivative product, a final sum and an output stage. The output stage applies a shift and a saturation. Every step issues exactly one operation to the shared datapath.

The loops are cascaded within an axis. The position loop output becomes the velocity setpoint, and the velocity loop output becomes the current setpoint. The current loop output is driven on the command port. The current loop runs on every pass. The velocity loop runs on one pass in `VEL_DIV`, and the position loop on one pass in `POS_DIV`. A loop that is not due keeps its last output.

Each controller has five signed 18-bit coefficients, held in a small RAM that is written while the engine is idle. The integrator uses anti-windup. The derivative works on the change of the error since that controller's previous evaluation. Setpoint and feedback inputs are expected to stay steady while a pass is running.

Top module: `pid_tdm_engine`

## Requirements
- R1: After reset, every command output is zero, busy is low and done is low, and all integrators, stored errors, cascade setpoints and coefficients are zero.
- R2: A start strobe seen while idle begins a pass on the next cycle. A strobe seen while a pass is running has no effect on timing or results.
- R3: A loop that is due takes 7 cycles and a loop that is not due takes 1 cycle. Busy is high for exactly the total of these cycles. Done is a one-cycle pulse in the cycle after the last step.
- R4: The error is setpoint minus feedback. The raw output is KP*e + KD*(e - e_prev) + I_new, where I_new = I + KI*e. This raw value is arithmetically shifted right by SHIFT.
- R5: The integrator accumulates KI times the error on every evaluation of its controller, unless R6 applies.
- R6: The integrator keeps its old value when the shifted output exceeds +LIMIT while the error is positive, or is below -LIMIT while the error is negative.
- R7: Each controller stores its error after every evaluation. The next evaluation of the same controller uses that stored error as e_prev.
- R8: Within an axis, the position loop output is the velocity setpoint and the velocity loop output is the current setpoint. Position feedback, velocity feedback and current feedback come from their own inputs.
- R9: On the first pass after reset all loops are due. After that, the velocity loop is due on every VEL_DIV-th pass and the position loop on every POS_DIV-th pass. A loop that is not due keeps its output.
- R10: Within a pass, loops run by ascending axis and, in each axis, in the order position, velocity, current. An axis's command output changes only in the cycle after that axis's current loop ends, and never while idle.
- R11: The coefficient address is {axis, loop, field}. The loop code is 0 for position, 1 for velocity and 2 for current. The field code (3 bits) is 0 for KP, 1 for KI, 2 for KD, 3 for SHIFT and 4 for LIMIT. Only the low 5 bits of SHIFT are used.
- R12: Every controller output is clamped to the range -LIMIT to +LIMIT, with LIMIT taken as non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-period strobe |
| cfg_we_i | input | 1 | Coefficient write enable |
| cfg_addr_i | input | AXW+5 | Coefficient address {axis, loop, field} |
| cfg_data_i | input | CW | Coefficient value, signed |
| pos_ref_i | input | NUM_AXES*DW | Position setpoint per axis, signed |
| pos_meas_i | input | NUM_AXES*DW | Position feedback per axis, signed |
| vel_meas_i | input | NUM_AXES*DW | Velocity feedback per axis, signed |
| cur_meas_i | input | NUM_AXES*DW | Current feedback per axis, signed |
| cur_cmd_o | output | NUM_AXES*DW | Current command per axis, signed |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | One-cycle pulse when a pass ends |

## Verification
Constant setpoints with mixed-sign errors across two axes exercise the cascade and the term arithmetic. Many repeated passes show whether the loop-rate dividers skip the outer loops and hold their outputs. Configuring one controller as integral-only, then as derivative-only, with changing feedback isolates the accumulation from the stored-error difference. Large errors of both signs drive outputs into the positive and negative limits, which separates a correct anti-windup hold from plain clamping. A second strobe in the middle of a pass shows whether the strobe is ignored while busy.

// File: rtl/pid_pkg.sv
package pid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERR,
        ST_PMUL,
        ST_IMUL,
        ST_DDIF,
        ST_DMUL,
        ST_SUM,
        ST_OUT
    } pid_state_e;

    localparam logic [1:0] LOOP_POS = 2'd0;
    localparam logic [1:0] LOOP_VEL = 2'd1;
    localparam logic [1:0] LOOP_CUR = 2'd2;

    localparam logic [2:0] F_KP    = 3'd0;
    localparam logic [2:0] F_KI    = 3'd1;
    localparam logic [2:0] F_KD    = 3'd2;
    localparam logic [2:0] F_SHIFT = 3'd3;
    localparam logic [2:0] F_LIMIT = 3'd4;

endpackage

// File: rtl/pid_coef_ram.sv
module pid_coef_ram #(
    parameter int CW  = 18,
    parameter int ADW = 6
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           we_i,
    input  logic [ADW-1:0] waddr_i,
    input  logic [CW-1:0]  wdata_i,
    input  logic [ADW-1:0] raddr_i,
    output logic [CW-1:0]  rdata_o
);
    localparam int DEPTH = 2 ** ADW;

    logic [CW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pid_mac.sv
module pid_mac #(
    parameter int CW = 18,
    parameter int BW = 20,
    parameter int AW = 40
) (
    input  logic                 mul_en_i,
    input  logic                 sub_i,
    input  logic signed [CW-1:0] coef_i,
    input  logic signed [BW-1:0] mul_b_i,
    input  logic signed [AW-1:0] add_a_i,
    input  logic signed [AW-1:0] add_b_i,
    output logic signed [AW-1:0] sum_o
);
    logic signed [AW-1:0] prod;
    logic signed [AW-1:0] term;

    always_comb begin
        prod  = AW'(coef_i) * AW'(mul_b_i);
        term  = mul_en_i ? prod : add_a_i;
        sum_o = sub_i ? (term - add_b_i) : (term + add_b_i);
    end
endmodule

// File: rtl/pid_limit.sv
module pid_limit #(
    parameter int AW = 40,
    parameter int DW = 18,
    parameter int CW = 18
) (
    input  logic signed [AW-1:0] acc_i,
    input  logic        [4:0]    shamt_i,
    input  logic signed [CW-1:0] limit_i,
    output logic signed [DW-1:0] out_o,
    output logic                 sat_hi_o,
    output logic                 sat_lo_o
);
    logic signed [AW-1:0] shifted;
    logic signed [AW-1:0] lim_pos;
    logic signed [AW-1:0] lim_neg;

    always_comb begin
        shifted  = acc_i >>> shamt_i;
        lim_pos  = AW'(limit_i);
        lim_neg  = -lim_pos;
        sat_hi_o = shifted > lim_pos;
        sat_lo_o = shifted < lim_neg;
        if (sat_hi_o)      out_o = lim_pos[DW-1:0];
        else if (sat_lo_o) out_o = lim_neg[DW-1:0];
        else               out_o = shifted[DW-1:0];
    end
endmodule

// File: rtl/pid_tdm_engine.sv
module pid_tdm_engine
    import pid_pkg::*;
#(
    parameter int NUM_AXES = 2,
    parameter int DW       = 18,
    parameter int CW       = 18,
    parameter int AW       = 40,
    parameter int VEL_DIV  = 4,
    parameter int POS_DIV  = 20,
    localparam int AXW     = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1,
    localparam int CFG_AW  = AXW + 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic                   cfg_we_i,
    input  logic [CFG_AW-1:0]      cfg_addr_i,
    input  logic [CW-1:0]          cfg_data_i,
    input  logic [NUM_AXES*DW-1:0] pos_ref_i,
    input  logic [NUM_AXES*DW-1:0] pos_meas_i,
    input  logic [NUM_AXES*DW-1:0] vel_meas_i,
    input  logic [NUM_AXES*DW-1:0] cur_meas_i,
    output logic [NUM_AXES*DW-1:0] cur_cmd_o,
    output logic                   busy_o,
    output logic                   done_o
);
    localparam int NCTL = NUM_AXES * 3;
    localparam int CTLW = $clog2(NCTL);
    localparam int VCW  = (VEL_DIV > 1) ? $clog2(VEL_DIV) : 1;
    localparam int PCW  = (POS_DIV > 1) ? $clog2(POS_DIV) : 1;
    localparam int BW   = DW + 2;

    typedef struct packed {
        pid_state_e                  st;
        logic [AXW-1:0]              axis;
        logic [1:0]                  loop;
        logic [VCW-1:0]              vcnt;
        logic [PCW-1:0]              pcnt;
        logic                        done;
        logic [4:0]                  shamt;
        logic [DW:0]                 err;
        logic [DW+1:0]               diff;
        logic [AW-1:0]               acc;
        logic [AW-1:0]               inew;
        logic [NCTL-1:0][AW-1:0]     integ;
        logic [NCTL-1:0][DW:0]       prev;
        logic [NUM_AXES-1:0][DW-1:0] vsp;
        logic [NUM_AXES-1:0][DW-1:0] csp;
        logic [NUM_AXES-1:0][DW-1:0] cmd;
    } regs_t;

    regs_t q, n;

    logic                 mul_en, sub, adv, due, hold;
    logic signed [BW-1:0] mul_b;
    logic signed [AW-1:0] add_a, add_b, mac_sum;
    logic [2:0]           field;
    logic [CW-1:0]        coef_rd;
    logic signed [DW-1:0] sp, fb, lim_out;
    logic                 sat_hi, sat_lo;
    logic [CTLW-1:0]      ctl;

    pid_coef_ram #(.CW(CW), .ADW(CFG_AW)) u_coef (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .waddr_i (cfg_addr_i),
        .wdata_i (cfg_data_i),
        .raddr_i ({q.axis, q.loop, field}),
        .rdata_o (coef_rd)
    );

    pid_mac #(.CW(CW), .BW(BW), .AW(AW)) u_mac (
        .mul_en_i (mul_en),
        .sub_i    (sub),
        .coef_i   ($signed(coef_rd)),
        .mul_b_i  (mul_b),
        .add_a_i  (add_a),
        .add_b_i  (add_b),
        .sum_o    (mac_sum)
    );

    pid_limit #(.AW(AW), .DW(DW), .CW(CW)) u_limit (
        .acc_i    ($signed(q.acc)),
        .shamt_i  (q.shamt),
        .limit_i  ($signed(coef_rd)),
        .out_o    (lim_out),
        .sat_hi_o (sat_hi),
        .sat_lo_o (sat_lo)
    );

    // Operand selection for the current controller
    always_comb begin
        ctl = CTLW'(q.axis) * CTLW'(3) + CTLW'(q.loop);
        unique case (q.loop)
            LOOP_POS: begin
                sp = $signed(pos_ref_i[q.axis*DW +: DW]);
                fb = $signed(pos_meas_i[q.axis*DW +: DW]);
            end
            LOOP_VEL: begin
                sp = $signed(q.vsp[q.axis]);
                fb = $signed(vel_meas_i[q.axis*DW +: DW]);
            end
            default: begin
                sp = $signed(q.csp[q.axis]);
                fb = $signed(cur_meas_i[q.axis*DW +: DW]);
            end
        endcase
        due = (q.loop == LOOP_CUR)
           || (q.loop == LOOP_VEL && q.vcnt == '0)
           || (q.loop == LOOP_POS && q.pcnt == '0);
        hold = (sat_hi && !q.err[DW] && q.err != '0) || (sat_lo && q.err[DW]);
    end

    // Next-state computation
    always_comb begin
        n      = q;
        n.done = 1'b0;
        adv    = 1'b0;
        mul_en = 1'b0;
        sub    = 1'b0;
        mul_b  = '0;
        add_a  = '0;
        add_b  = '0;
        field  = F_KP;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n.st   = ST_ERR;
                    n.axis = '0;
                    n.loop = LOOP_POS;
                end
            end
            ST_ERR: begin
                if (due) begin
                    add_a = AW'(sp);
                    add_b = AW'(fb);
                    sub   = 1'b1;
                    n.err = mac_sum[DW:0];
                    n.st  = ST_PMUL;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_PMUL: begin
                field  = F_KP;
                mul_en = 1'b1;
                mul_b  = BW'($signed(q.err));
                n.acc  = mac_sum;
                n.st   = ST_IMUL;
            end
            ST_IMUL: begin
                field  = F_KI;
                mul_en = 1'b1;
                mul_b  = BW'($signed(q.err));
                add_b  = $signed(q.integ[ctl]);
                n.inew = mac_sum;
                n.st   = ST_DDIF;
            end
            ST_DDIF: begin
                add_a  = AW'($signed(q.err));
                add_b  = AW'($signed(q.prev[ctl]));
                sub    = 1'b1;
                n.diff = mac_sum[DW+1:0];
                n.st   = ST_DMUL;
            end
            ST_DMUL: begin
                field  = F_KD;
                mul_en = 1'b1;
                mul_b  = $signed(q.diff);
                add_b  = $signed(q.acc);
                n.acc  = mac_sum;
                n.st   = ST_SUM;
            end
            ST_SUM: begin
                field   = F_SHIFT;
                add_a   = $signed(q.acc);
                add_b   = $signed(q.inew);
                n.acc   = mac_sum;
                n.shamt = coef_rd[4:0];
                n.st    = ST_OUT;
            end
            ST_OUT: begin
                field = F_LIMIT;
                unique case (q.loop)
                    LOOP_POS: n.vsp[q.axis] = lim_out;
                    LOOP_VEL: n.csp[q.axis] = lim_out;
                    default:  n.cmd[q.axis] = lim_out;
                endcase
                if (!hold) n.integ[ctl] = q.inew;
                n.prev[ctl] = q.err;
                adv = 1'b1;
            end
            default: n.st = ST_IDLE;
        endcase

        if (adv) begin
            if (q.loop == LOOP_CUR) begin
                n.loop = LOOP_POS;
                if (q.axis == AXW'(NUM_AXES - 1)) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.vcnt = (q.vcnt == VCW'(VEL_DIV - 1)) ? '0 : q.vcnt + 1'b1;
                    n.pcnt = (q.pcnt == PCW'(POS_DIV - 1)) ? '0 : q.pcnt + 1'b1;
                end else begin
                    n.axis = q.axis + 1'b1;
                    n.st   = ST_ERR;
                end
            end else begin
                n.loop = q.loop + 1'b1;
                n.st   = ST_ERR;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign cur_cmd_o = q.cmd;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
endmodule

// File: rtl/pid_tdm_engine_checker.sv
module pid_tdm_engine_checker #(
    parameter int NUM_AXES = 2,
    parameter int DW       = 18,
    parameter int CW       = 18
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [NUM_AXES*DW-1:0] cur_cmd,
    input logic                   out_step,
    input logic [DW-1:0]          lim_out,
    input logic [CW-1:0]          lim_val
);
    // R3: done is a single-cycle pulse
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done follows the last busy cycle
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R2: a strobe while idle starts a pass
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: commands never move while idle
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cur_cmd));

    // R12: limiter output within the configured bound
    p_limit_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_step && !lim_val[CW-1]) |->
            (($signed(lim_out) <= $signed(lim_val)) &&
             ($signed(lim_out) >= -$signed(lim_val))));
endmodule

bind pid_tdm_engine pid_tdm_engine_checker #(
    .NUM_AXES (NUM_AXES),
    .DW       (DW),
    .CW       (CW)
) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .start    (start_i),
    .busy     (busy_o),
    .done     (done_o),
    .cur_cmd  (cur_cmd_o),
    .out_step (q.st == pid_pkg::ST_OUT),
    .lim_out  (lim_out),
    .lim_val  (coef_rd)
);

// File: tb/pid_tdm_engine_bench.sv
`timescale 1ns/1ps
module pid_tdm_engine_bench;
    localparam int NA  = 2;
    localparam int DW  = 18;
    localparam int VD  = 2;
    localparam int PD  = 3;
    localparam int CAW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [17:0] cfg_data = '0;
    logic [NA*DW-1:0] pos_ref, pos_meas, vel_meas, cur_meas, cur_cmd;
    logic busy, done;

    int sp_pos [NA];
    int fb_pos [NA];
    int fb_vel [NA];
    int fb_cur [NA];

    always #4 clk = ~clk;

    always_comb begin
        for (int a = 0; a < NA; a++) begin
            pos_ref[a*DW +: DW]  = DW'(sp_pos[a]);
            pos_meas[a*DW +: DW] = DW'(fb_pos[a]);
            vel_meas[a*DW +: DW] = DW'(fb_vel[a]);
            cur_meas[a*DW +: DW] = DW'(fb_cur[a]);
        end
    end

    pid_tdm_engine #(.NUM_AXES(NA), .DW(DW), .VEL_DIV(VD), .POS_DIV(PD)) u_pid_tdm_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .pos_ref_i(pos_ref), .pos_meas_i(pos_meas), .vel_meas_i(vel_meas),
        .cur_meas_i(cur_meas), .cur_cmd_o(cur_cmd), .busy_o(busy), .done_o(done)
    );

    // Behavioural reference
    longint coef [64];
    longint integ [NA*3];
    longint prev [NA*3];
    longint vsp [NA];
    longint csp [NA];
    longint m_cmd [NA];
    longint ev_v [NA];
    int ev_t [NA];
    int vcnt, pcnt, m_n, m_total;
    bit m_busy, m_done;
    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    task automatic model_pass();
        int t = 0;
        for (int a = 0; a < NA; a++) begin
            for (int l = 0; l < 3; l++) begin
                bit due = (l == 2) || (l == 1 && vcnt == 0) || (l == 0 && pcnt == 0);
                int base = a*32 + l*8;
                int c = a*3 + l;
                longint sp, fb, e, inew, acc, sh, lim, o;
                if (!due) begin
                    t += 1;
                    continue;
                end
                t += 7;
                sp = (l == 0) ? longint'(sp_pos[a]) : (l == 1) ? vsp[a] : csp[a];
                fb = (l == 0) ? longint'(fb_pos[a]) : (l == 1) ? longint'(fb_vel[a]) : longint'(fb_cur[a]);
                e    = sp - fb;
                inew = integ[c] + coef[base+1] * e;
                acc  = coef[base] * e + coef[base+2] * (e - prev[c]) + inew;
                sh   = acc >>> (coef[base+3] & 31);
                lim  = coef[base+4];
                o    = (sh > lim) ? lim : (sh < -lim) ? -lim : sh;
                if (!((sh > lim && e > 0) || (sh < -lim && e < 0))) integ[c] = inew;
                prev[c] = e;
                if (l == 0) vsp[a] = o;
                else if (l == 1) csp[a] = o;
                else begin
                    ev_t[a] = t;
                    ev_v[a] = o;
                end
            end
        end
        m_total = t;
        vcnt = (vcnt == VD-1) ? 0 : vcnt + 1;
        pcnt = (pcnt == PD-1) ? 0 : pcnt + 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (coef[i]) coef[i] = 0;
            foreach (integ[i]) begin integ[i] = 0; prev[i] = 0; end
            foreach (vsp[i]) begin vsp[i] = 0; csp[i] = 0; m_cmd[i] = 0; ev_t[i] = -1; end
            vcnt = 0; pcnt = 0; m_busy = 0; m_done = 0; m_n = 0; m_total = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_n++;
                for (int a = 0; a < NA; a++) if (m_n == ev_t[a]) m_cmd[a] = ev_v[a];
                if (m_n == m_total) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start) begin
                model_pass();
                m_busy = 1;
                m_n = 0;
            end
            if (cfg_we) coef[cfg_addr] = longint'($signed(cfg_data));
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (busy !== m_busy) begin
                n_bad++;
                $display("FAIL R3 (%s): busy_o actual %0d expected %0d", tag, busy, m_busy);
            end
            n_cmp++;
            if (done !== m_done) begin
                n_bad++;
                $display("FAIL R3 (%s): done_o actual %0d expected %0d", tag, done, m_done);
            end
            for (int a = 0; a < NA; a++) begin
                n_cmp++;
                if (longint'($signed(cur_cmd[a*DW +: DW])) != m_cmd[a]) begin
                    n_bad++;
                    $display("FAIL %s: cur_cmd[%0d] actual %0d expected %0d",
                             tag, a, $signed(cur_cmd[a*DW +: DW]), m_cmd[a]);
                end
            end
        end
    end

    task automatic wr(input int a, input int l, input int f, input int v);
        cfg_we = 1'b1;
        cfg_addr = CAW'(a*32 + l*8 + f);
        cfg_data = 18'(v);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic wr_loop(input int a, input int l, input int kp, input int ki,
                           input int kd, input int sh, input int lim);
        wr(a, l, 0, kp); wr(a, l, 1, ki); wr(a, l, 2, kd); wr(a, l, 3, sh); wr(a, l, 4, lim);
    endtask

    task automatic run_pass(input bit restrobe);
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        if (restrobe) begin
            repeat (9) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
        end
        do begin
            @(posedge clk); #2;
        end while (m_busy);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) begin
            sp_pos[a] = 0; fb_pos[a] = 0; fb_vel[a] = 0; fb_cur[a] = 0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tag = "R1 reset state";
        repeat (4) @(posedge clk);
        #2;

        tag = "R11 coefficient addressing";
        wr_loop(0, 0, 2, 0, 0, 0, 1000);
        wr_loop(0, 1, 3, 1, 2, 1, 5000);
        wr_loop(0, 2, 4, 1, 1, 2, 2000);
        wr_loop(1, 0, 1, 0, 0, 0, 300);
        wr_loop(1, 1, 1, 2, 0, 0, 400);
        wr_loop(1, 2, 2, 1, 3, 1, 100);
        sp_pos[0] = 100; fb_pos[0] = 40; fb_vel[0] = 30; fb_cur[0] = 20;
        sp_pos[1] = -50; fb_pos[1] = 10; fb_vel[1] = -5; fb_cur[1] = 3;
        run_pass(1'b0);

        tag = "R4 R8 R10 arithmetic and cascade";
        for (int i = 0; i < 3; i++) run_pass(1'b0);

        tag = "R9 loop rates";
        for (int i = 0; i < 7; i++) begin
            fb_pos[0] = 40 + i*3;
            fb_vel[1] = -5 + i;
            run_pass(1'b0);
        end

        tag = "R2 strobe while busy";
        run_pass(1'b1);
        run_pass(1'b1);

        tag = "R6 R12 saturation and anti-windup";
        fb_cur[1] = -3000;
        for (int i = 0; i < 4; i++) run_pass(1'b0);
        fb_cur[1] = 3000;
        for (int i = 0; i < 4; i++) run_pass(1'b0);
        fb_cur[1] = 3;

        tag = "R5 integral only";
        wr_loop(0, 2, 0, 1, 0, 0, 100000);
        for (int i = 0; i < 4; i++) begin
            fb_cur[0] = 20 + i*7;
            run_pass(1'b0);
        end

        tag = "R7 derivative only";
        wr_loop(0, 2, 0, 0, 5, 0, 100000);
        for (int i = 0; i < 4; i++) begin
            fb_cur[0] = (i % 2 == 0) ? -40 : 60;
            run_pass(1'b0);
        end

        tag = "R11 shift low bits";
        wr_loop(0, 2, 4, 1, 1, 35, 2000);
        for (int i = 0; i < 3; i++) run_pass(1'b0);

        repeat (3) @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule